// File: doc/BRIEF.md
# Iterative CORDIC Engine

This block computes sines, cosines, magnitudes and phase angles with the CORDIC method. It performs one micro-rotation per clock, using only arithmetic shifts, additions and subtractions. A small arctangent table in binary angle units supplies the angle step for each iteration. A single datapath serves two modes. In rotation mode, a magnitude and an angle are turned into x and y components. In vectoring mode, an x and y pair is turned into a magnitude and a phase angle.

A caller presents signed 12-bit operands, a 16-bit angle and a mode bit, then pulses `start`. The engine loads its registers and runs 14 micro-rotations. The direction of each step depends on the mode: in rotation mode it follows the sign of the residual angle, and in vectoring mode the sign of y. The engine then applies the constant gain correction of about 0.60726. In rotation mode this correction is applied while loading; in vectoring mode it is applied to the final x. The engine rounds the results into the output registers and pulses `done` for one clock.

Inside, x and y carry two headroom bits and four fraction bits beyond the 12-bit I/O width. The controller has four states:
- ST_IDLE waits for `start`, then goes to ST_STEP.
- ST_STEP runs the iterations and moves to ST_SCALE after the last one.
- ST_SCALE formats and captures the results, then goes to ST_DONE.
- ST_DONE raises `done` for one clock and returns to ST_IDLE.

Top module: `cordic_engine`

## Requirements
- R1: After reset, `busy` and `done` are 0 and `res_x`, `res_y`, `res_ang` are 0.
- R2: A `start` seen at a clock edge while `busy` is 0 makes `busy` 1 from the next cycle. `done` is 1 for exactly one cycle, beginning at the 15th edge after the accepting edge (ITERS+1). At the edge after that, `busy` and `done` both return to 0.
- R3: A `start` pulse while `busy` is 1 is ignored. The running operation finishes with its own operands and on its own schedule.
- R4: With `mode`=0 (rotation), `in_x`=m ≥ 0 and a signed angle `in_ang`=a in binary angle units (32768 = 180 degrees) with |a| ≤ 16384: `res_x` is within 2 LSB of m·cos(a) and `res_y` is within 2 LSB of m·sin(a).
- R5: In rotation mode, `res_ang` reports the residual angle, and its magnitude is at most 4 units.
- R6: In rotation mode, `in_y` has no effect on any result.
- R7: With `mode`=1 (vectoring) and `in_x` ≥ 0: `res_x` is within 2 LSB of sqrt(x²+y²), and `res_ang` is within 6 units of atan2(y, x) in binary angle units. The magnitude is never negative.
- R8: In vectoring mode, `res_y` reports the residual y, which is within 2 LSB of 0.
- R9: A result outside the signed 12-bit range saturates to +2047 or −2048.
- R10: `res_x`, `res_y` and `res_ang` change only at the edge that raises `done`. They hold their values between operations, whatever the inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (accepted only when idle) |
| mode | input | 1 | 0 = rotation, 1 = vectoring |
| in_x | input | 12 | Rotation: magnitude; vectoring: x (≥ 0) |
| in_y | input | 12 | Vectoring: y; unused in rotation |
| in_ang | input | 16 | Rotation: angle, 32768 = 180 degrees |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse, results valid |
| res_x | output | 12 | Rotation: x component; vectoring: magnitude |
| res_y | output | 12 | Rotation: y component; vectoring: residual y |
| res_ang | output | 16 | Rotation: residual angle; vectoring: phase |

## Verification
The bench drives angles at ±90 degrees, exact multiples of 45 degrees and zero. These cases catch a swapped direction rule or a wrong table entry, either of which leaves the vector far off target or makes the residual angle diverge.

In vectoring mode, the bench uses x = 0, negative y and vectors longer than 2047. These cases expose a missing gain correction (magnitude about 1.65 times too large) and a missing clamp (a large magnitude wraps to a negative number).

The bench pulses `start` mid-operation and toggles the inputs while idle. A design that restarts on a busy start would return the second operand's result late. A design whose output registers follow the datapath would show results changing between operations.

// File: rtl/cordic_pkg.sv
package cordic_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_STEP,
        ST_SCALE,
        ST_DONE
    } cordic_state_e;

    typedef enum logic {
        MODE_ROTATE = 1'b0,
        MODE_VECTOR = 1'b1
    } cordic_mode_e;

endpackage

// File: rtl/cordic_fsm.sv
module cordic_fsm
    import cordic_pkg::*;
#(
    parameter int ITERS = 14,
    parameter int IDXW  = $clog2(ITERS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    output logic            load,
    output logic            step,
    output logic            capture,
    output logic            busy,
    output logic            done,
    output logic [IDXW-1:0] idx
);

    cordic_state_e state_q;
    cordic_state_e state_nx;
    logic          last_step;

    assign last_step = (idx == IDXW'(ITERS - 1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_nx;
        end
    end

    // iteration index
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx <= '0;
        end else if (load) begin
            idx <= '0;
        end else if (step) begin
            idx <= idx + 1'b1;
        end
    end

    // transitions
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_nx = ST_STEP;
            ST_STEP:  if (last_step) state_nx = ST_SCALE;
            ST_SCALE: state_nx = ST_DONE;
            ST_DONE:  state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        load    = 1'b0;
        step    = 1'b0;
        capture = 1'b0;
        busy    = 1'b1;
        done    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                busy = 1'b0;
                load = start;
            end
            ST_STEP:  step    = 1'b1;
            ST_SCALE: capture = 1'b1;
            ST_DONE:  done    = 1'b1;
            default:  busy    = 1'b0;
        endcase
    end

endmodule

// File: rtl/cordic_atan_rom.sv
module cordic_atan_rom #(
    parameter int AW   = 16,
    parameter int IDXW = 4
) (
    input  logic [IDXW-1:0]        idx,
    output logic signed [AW-1:0]   step_ang
);

    // arctan(2^-i) in units where 2^15 = 180 degrees, for a 16-bit angle
    logic [15:0] base;

    always_comb begin
        unique case (32'(idx))
            0:       base = 16'd8192;
            1:       base = 16'd4836;
            2:       base = 16'd2555;
            3:       base = 16'd1297;
            4:       base = 16'd651;
            5:       base = 16'd326;
            6:       base = 16'd163;
            7:       base = 16'd81;
            8:       base = 16'd41;
            9:       base = 16'd20;
            10:      base = 16'd10;
            11:      base = 16'd5;
            12:      base = 16'd3;
            13:      base = 16'd1;
            default: base = 16'(32'd10430 >> idx);
        endcase
    end

    generate
        if (AW >= 16) begin : g_wide
            assign step_ang = $signed({1'b0, base}) <<< (AW - 16);
        end else begin : g_narrow
            assign step_ang = AW'(base >> (16 - AW));
        end
    endgenerate

endmodule

// File: rtl/cordic_rotator.sv
module cordic_rotator #(
    parameter int W    = 18,
    parameter int AW   = 16,
    parameter int IDXW = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic                 step,
    input  logic                 vec_mode,
    input  logic signed [W-1:0]  x0,
    input  logic signed [W-1:0]  y0,
    input  logic signed [AW-1:0] z0,
    input  logic [IDXW-1:0]      idx,
    input  logic signed [AW-1:0] step_ang,
    output logic signed [W-1:0]  x_q,
    output logic signed [W-1:0]  y_q,
    output logic signed [AW-1:0] z_q
);

    logic                dir_pos;
    logic signed [W-1:0] x_sh;
    logic signed [W-1:0] y_sh;
    logic signed [W-1:0] x_nx;
    logic signed [W-1:0] y_nx;
    logic signed [AW-1:0] z_nx;

    // rotation: follow the residual angle; vectoring: drive y toward zero
    assign dir_pos = vec_mode ? y_q[W-1] : (z_q > 0);

    assign x_sh = x_q >>> idx;
    assign y_sh = y_q >>> idx;

    always_comb begin
        if (dir_pos) begin
            x_nx = x_q - y_sh;
            y_nx = y_q + x_sh;
            z_nx = z_q - step_ang;
        end else begin
            x_nx = x_q + y_sh;
            y_nx = y_q - x_sh;
            z_nx = z_q + step_ang;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            x_q <= '0;
            y_q <= '0;
            z_q <= '0;
        end else if (load) begin
            x_q <= x0;
            y_q <= y0;
            z_q <= z0;
        end else if (step) begin
            x_q <= x_nx;
            y_q <= y_nx;
            z_q <= z_nx;
        end
    end

endmodule

// File: rtl/cordic_gain.sv
module cordic_gain #(
    parameter int W     = 18,
    parameter int KW    = 16,
    parameter int KFRAC = 15,
    parameter int KVAL  = 19899
) (
    input  logic signed [W-1:0] a,
    output logic signed [W-1:0] p
);

    localparam int PW = W + KW;
    localparam logic signed [PW-1:0] KCONST = PW'(KVAL);
    localparam logic signed [PW-1:0] RND    = PW'(1) <<< (KFRAC - 1);

    logic signed [PW-1:0] prod;

    assign prod = PW'(a) * KCONST;
    assign p    = W'((prod + RND) >>> KFRAC);

endmodule

// File: rtl/cordic_outfmt.sv
module cordic_outfmt #(
    parameter int W    = 18,
    parameter int FRAC = 4,
    parameter int DW   = 12
) (
    input  logic signed [W-1:0]  v,
    output logic signed [DW-1:0] q
);

    localparam int SW = W - FRAC + 1;
    localparam logic signed [W:0]    RND  = (W + 1)'(1) <<< (FRAC - 1);
    localparam logic signed [SW-1:0] QMAX = SW'((2 ** (DW - 1)) - 1);
    localparam logic signed [SW-1:0] QMIN = SW'(-(2 ** (DW - 1)));

    logic signed [W:0]    sum;
    logic signed [SW-1:0] sh;

    assign sum = {v[W-1], v} + RND;
    assign sh  = SW'(sum >>> FRAC);

    always_comb begin
        if (sh > QMAX) begin
            q = {1'b0, {(DW - 1){1'b1}}};
        end else if (sh < QMIN) begin
            q = {1'b1, {(DW - 1){1'b0}}};
        end else begin
            q = sh[DW-1:0];
        end
    end

endmodule

// File: rtl/cordic_engine.sv
module cordic_engine
    import cordic_pkg::*;
#(
    parameter int DW    = 12,
    parameter int HEAD  = 2,
    parameter int FRAC  = 4,
    parameter int AW    = 16,
    parameter int ITERS = 14,
    parameter int KVAL  = 19899,
    parameter int KFRAC = 15
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 mode,
    input  logic signed [DW-1:0] in_x,
    input  logic signed [DW-1:0] in_y,
    input  logic signed [AW-1:0] in_ang,
    output logic                 busy,
    output logic                 done,
    output logic signed [DW-1:0] res_x,
    output logic signed [DW-1:0] res_y,
    output logic signed [AW-1:0] res_ang
);

    localparam int W    = DW + HEAD + FRAC;
    localparam int IDXW = $clog2(ITERS);

    logic            load;
    logic            step;
    logic            capture;
    logic [IDXW-1:0] idx;
    logic            mode_q;

    logic signed [W-1:0]  x_ext;
    logic signed [W-1:0]  y_ext;
    logic signed [W-1:0]  x_pre;
    logic signed [W-1:0]  x0;
    logic signed [W-1:0]  y0;
    logic signed [AW-1:0] z0;
    logic signed [AW-1:0] step_ang;
    logic signed [W-1:0]  x_q;
    logic signed [W-1:0]  y_q;
    logic signed [AW-1:0] z_q;
    logic signed [W-1:0]  x_fin;

    logic signed [W-1:0]  lane_in  [2];
    logic signed [DW-1:0] lane_out [2];

    cordic_fsm #(
        .ITERS(ITERS),
        .IDXW (IDXW)
    ) u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .load   (load),
        .step   (step),
        .capture(capture),
        .busy   (busy),
        .done   (done),
        .idx    (idx)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= 1'b0;
        end else if (load) begin
            mode_q <= mode;
        end
    end

    // operands widened with headroom and fraction bits
    assign x_ext = {{HEAD{in_x[DW-1]}}, in_x, {FRAC{1'b0}}};
    assign y_ext = {{HEAD{in_y[DW-1]}}, in_y, {FRAC{1'b0}}};

    cordic_gain #(
        .W    (W),
        .KFRAC(KFRAC),
        .KVAL (KVAL)
    ) u_gain_pre (
        .a(x_ext),
        .p(x_pre)
    );

    always_comb begin
        if (cordic_mode_e'(mode) == MODE_VECTOR) begin
            x0 = x_ext;
            y0 = y_ext;
            z0 = '0;
        end else begin
            x0 = x_pre;
            y0 = '0;
            z0 = in_ang;
        end
    end

    cordic_atan_rom #(
        .AW  (AW),
        .IDXW(IDXW)
    ) u_rom (
        .idx     (idx),
        .step_ang(step_ang)
    );

    cordic_rotator #(
        .W   (W),
        .AW  (AW),
        .IDXW(IDXW)
    ) u_rot (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .step    (step),
        .vec_mode(mode_q),
        .x0      (x0),
        .y0      (y0),
        .z0      (z0),
        .idx     (idx),
        .step_ang(step_ang),
        .x_q     (x_q),
        .y_q     (y_q),
        .z_q     (z_q)
    );

    cordic_gain #(
        .W    (W),
        .KFRAC(KFRAC),
        .KVAL (KVAL)
    ) u_gain_post (
        .a(x_q),
        .p(x_fin)
    );

    assign lane_in[0] = mode_q ? x_fin : x_q;
    assign lane_in[1] = y_q;

    for (genvar g = 0; g < 2; g++) begin : g_fmt
        cordic_outfmt #(
            .W   (W),
            .FRAC(FRAC),
            .DW  (DW)
        ) u_fmt (
            .v(lane_in[g]),
            .q(lane_out[g])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_x   <= '0;
            res_y   <= '0;
            res_ang <= '0;
        end else if (capture) begin
            res_x   <= lane_out[0];
            res_y   <= lane_out[1];
            res_ang <= z_q;
        end
    end

endmodule

// File: rtl/cordic_engine_chk.sv
module cordic_engine_chk #(
    parameter int DW    = 12,
    parameter int AW    = 16,
    parameter int ITERS = 14
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 start,
    input logic                 busy,
    input logic                 done,
    input logic                 vec_mode,
    input logic signed [DW-1:0] res_x,
    input logic signed [DW-1:0] res_y,
    input logic signed [AW-1:0] res_ang
);

    localparam int CW = $clog2(ITERS + 2) + 1;

    logic          lat_act;
    logic [CW-1:0] lat_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_act <= 1'b0;
            lat_cnt <= '0;
        end else if (start && !busy) begin
            lat_act <= 1'b1;
            lat_cnt <= '0;
        end else if (done) begin
            lat_act <= 1'b0;
        end else if (lat_act) begin
            lat_cnt <= lat_cnt + 1'b1;
        end
    end

    // R2
    accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && !done));

    // R2
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2 R3
    done_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (lat_act && lat_cnt == CW'(ITERS + 1)));

    // R3
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && busy && !done) |=> busy);

    // R10
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({res_x, res_y, res_ang}) |-> done);

    // R7
    mag_nonneg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && vec_mode) |-> !res_x[DW-1]);

endmodule

bind cordic_engine cordic_engine_chk #(
    .DW   (DW),
    .AW   (AW),
    .ITERS(ITERS)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .vec_mode(mode_q),
    .res_x   (res_x),
    .res_y   (res_y),
    .res_ang (res_ang)
);

// File: tb/cordic_engine_test.sv
module cordic_engine_test;

    localparam int  DW = 12;
    localparam int  AW = 16;
    localparam real PI = 3.14159265358979;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 start = 1'b0;
    logic                 mode = 1'b0;
    logic signed [DW-1:0] in_x = '0;
    logic signed [DW-1:0] in_y = '0;
    logic signed [AW-1:0] in_ang = '0;
    logic                 busy;
    logic                 done;
    logic signed [DW-1:0] res_x;
    logic signed [DW-1:0] res_y;
    logic signed [AW-1:0] res_ang;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    cordic_engine uut (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .mode   (mode),
        .in_x   (in_x),
        .in_y   (in_y),
        .in_ang (in_ang),
        .busy   (busy),
        .done   (done),
        .res_x  (res_x),
        .res_y  (res_y),
        .res_ang(res_ang)
    );

    task automatic check_int(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic check_near(input string req, input string what, input int act,
                              input real exp, input real tol);
        real diff;
        n_checks++;
        diff = $itor(act) - exp;
        if (diff < 0.0) diff = -diff;
        if (diff > tol) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%f (tol %f)", req, what, act, exp, tol);
        end
    endtask

    task automatic run_op(input bit m, input int x, input int y, input int a, output int lat);
        @(negedge clk);
        mode   = m;
        in_x   = DW'(x);
        in_y   = DW'(y);
        in_ang = AW'(a);
        start  = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat   = 1;
        while (!done && lat < 100) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic rot_case(input int mag, input int a);
        int  lat;
        real th;
        run_op(1'b0, mag, 0, a, lat);
        th = $itor(a) * PI / 32768.0;
        check_near("R4", "rotation x", int'(res_x), $itor(mag) * $cos(th), 2.0);
        check_near("R4", "rotation y", int'(res_y), $itor(mag) * $sin(th), 2.0);
        check_near("R5", "rotation residual angle", int'(res_ang), 0.0, 4.0);
    endtask

    task automatic vec_case(input int x, input int y);
        int  lat;
        real mag;
        real ang;
        run_op(1'b1, x, y, 0, lat);
        mag = $sqrt($itor(x) * $itor(x) + $itor(y) * $itor(y));
        ang = $atan2($itor(y), $itor(x)) * 32768.0 / PI;
        check_near("R7", "vectoring magnitude", int'(res_x), mag, 2.0);
        check_near("R7", "vectoring angle", int'(res_ang), ang, 6.0);
        check_near("R8", "vectoring residual y", int'(res_y), 0.0, 2.0);
    endtask

    task automatic test_reset();
        check_int("R1", "busy after reset", int'(busy), 0);
        check_int("R1", "done after reset", int'(done), 0);
        check_int("R1", "res_x after reset", int'(res_x), 0);
        check_int("R1", "res_y after reset", int'(res_y), 0);
        check_int("R1", "res_ang after reset", int'(res_ang), 0);
    endtask

    task automatic test_timing();
        int lat;
        run_op(1'b0, 1000, 0, 5461, lat);
        check_int("R2", "done latency in edges", lat, 16);
        check_int("R2", "busy while done", int'(busy), 1);
        @(negedge clk);
        check_int("R2", "done width one cycle", int'(done), 0);
        check_int("R2", "busy after done", int'(busy), 0);
    endtask

    task automatic test_rotation();
        rot_case(1000, 0);
        rot_case(1000, 5461);
        rot_case(2047, -8192);
        rot_case(1500, 16384);
        rot_case(1800, -16384);
        rot_case(700, 12000);
    endtask

    task automatic test_ignore_y();
        int lat;
        int ax;
        int ay;
        int aa;
        run_op(1'b0, 1200, 0, 3641, lat);
        ax = int'(res_x);
        ay = int'(res_y);
        aa = int'(res_ang);
        run_op(1'b0, 1200, -1777, 3641, lat);
        check_int("R6", "x with in_y set", int'(res_x), ax);
        check_int("R6", "y with in_y set", int'(res_y), ay);
        check_int("R6", "angle with in_y set", int'(res_ang), aa);
    endtask

    task automatic test_vectoring();
        vec_case(1000, 0);
        vec_case(1200, 900);
        vec_case(300, -1800);
        vec_case(0, 1500);
        vec_case(1400, -1400);
    endtask

    task automatic test_saturation();
        int lat;
        run_op(1'b1, 2047, 2047, 0, lat);
        check_int("R9", "saturated magnitude", int'(res_x), 2047);
        check_near("R9", "angle with saturated magnitude", int'(res_ang), 8192.0, 6.0);
        run_op(1'b1, 1800, -1800, 0, lat);
        check_int("R9", "saturated magnitude negative y", int'(res_x), 2047);
        check_near("R9", "angle negative y saturated", int'(res_ang), -8192.0, 6.0);
    endtask

    task automatic test_start_ignored();
        int lat;
        @(negedge clk);
        mode   = 1'b0;
        in_x   = DW'(1000);
        in_y   = '0;
        in_ang = AW'(-5461);
        start  = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat   = 1;
        repeat (4) begin
            @(negedge clk);
            lat++;
        end
        mode   = 1'b1;
        in_x   = DW'(500);
        in_y   = DW'(500);
        in_ang = '0;
        start  = 1'b1;
        @(negedge clk);
        lat++;
        start = 1'b0;
        while (!done && lat < 100) begin
            @(negedge clk);
            lat++;
        end
        check_int("R3", "latency with busy start", lat, 16);
        check_near("R3", "x of first operation", int'(res_x), 1000.0 * $cos(-PI / 6.0), 2.0);
        check_near("R3", "y of first operation", int'(res_y), 1000.0 * $sin(-PI / 6.0), 2.0);
    endtask

    task automatic test_hold();
        int lat;
        int ax;
        int ay;
        int aa;
        run_op(1'b1, 900, 400, 0, lat);
        ax = int'(res_x);
        ay = int'(res_y);
        aa = int'(res_ang);
        @(negedge clk);
        mode   = 1'b0;
        in_x   = DW'(-300);
        in_y   = DW'(1234);
        in_ang = AW'(9999);
        repeat (6) @(negedge clk);
        check_int("R10", "res_x held", int'(res_x), ax);
        check_int("R10", "res_y held", int'(res_y), ay);
        check_int("R10", "res_ang held", int'(res_ang), aa);
    endtask

    initial begin
        #(200000 * 8);
        n_fail++;
        $display("FAIL R2 watchdog: run did not finish, actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        @(negedge clk);
        test_timing();
        test_rotation();
        test_ignore_y();
        test_vectoring();
        test_saturation();
        test_start_ignored();
        test_hold();
        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule